// File: doc/BRIEF.md
# Shift-and-Add Transposed Low-Pass FIR

This block is a nine-tap low-pass FIR filter whose integer coefficient set is fixed in hardware. It contains no general multiplier. Each distinct coefficient product is formed once, from sign-extended, left-shifted copies of the incoming sample. The five distinct products feed the nine taps, because the coefficient set is mirror-symmetric about its centre tap.

Partial sums travel through a transposed register chain toward the output. They are held in carry-save form: a sum word and a carry word per stage. Each stage folds its product terms into the incoming pair with two 3:2 compressors. A single carry-propagate addition at the output resolves the pair into a two's-complement result.

The filter accepts one sample on each cycle where the input strobe is high. It returns one full-precision result on the next cycle. Cycles without the strobe leave the filter state untouched.

Top module: `tfir_shiftadd`

## Requirements
- R1: The output for an accepted sample is y[n] = sum over k=0..8 of h[k]*x[n-k], where x[n-k] is the k-th most recent accepted sample. The tap weights for k=0..8 are h = 9, 16, 17, 32, 33, 32, 17, 16, 9. A single nonzero sample followed by zeros therefore yields these nine weights, each scaled by that sample.
- R2: `out_valid` is high on exactly the cycle after each cycle in which `in_valid` is high, and is low otherwise.
- R3: `out_data` is a 24-bit two's-complement value that holds the exact sum with no wrap. This includes runs of full-scale positive samples (+32767, giving +5930827) and full-scale negative samples (-32768, giving -5931008).
- R4: A cycle with `in_valid` low changes no filter state. `out_data` holds its previous value, and later outputs are the same as if the idle cycles had not occurred.
- R5: While `rst_n` is low, `out_valid` and `out_data` are 0 and every partial sum is cleared. The first sample accepted after reset therefore yields exactly 9 times that sample, and later outputs treat every sample older than the reset as zero.
- R6: `in_data` is a 16-bit two's-complement sample, and any mix of signs gives the exact signed convolution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Sample strobe; the sample on in_data is accepted while high |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| out_data | output | 24 | Signed filter result, held between results |

## Verification
On every cycle, the assertions check four things: the one-cycle relation between the input strobe and `out_valid`, that the output holds across idle cycles, that results stay within the full-scale gain bound, and that the first result after reset equals nine times the first accepted sample. Only the bench's scenarios can show that the whole convolution is correct. Those scenarios are the impulse response, full-scale runs of each sign, pseudo-random mixed-sign streams, streams broken by idle gaps, and a reset in the middle of a stream. In each of them, every result is compared against a reference convolution kept in the bench.

// File: rtl/tfir_pkg.sv
package tfir_pkg;

  localparam int NTAPS = 9;
  localparam int NUNIQ = (NTAPS + 1) / 2;

  // Left shift applied to the sample for the dominant term of coefficient j
  function automatic int coef_shift(input int j);
    case (j)
      0:       return 3;
      1, 2:    return 4;
      default: return 5;
    endcase
  endfunction

  // Whether coefficient j adds an unshifted copy of the sample
  function automatic bit coef_unit(input int j);
    return (j % 2) == 0;
  endfunction

  function automatic int coef_value(input int j);
    return (1 << coef_shift(j)) + (coef_unit(j) ? 1 : 0);
  endfunction

  // Tap k uses the shared product of its mirrored coefficient
  function automatic int mirror_idx(input int k);
    return (k < NUNIQ) ? k : (NTAPS - 1 - k);
  endfunction

  function automatic int gain_sum();
    int acc;
    acc = 0;
    for (int k = 0; k < NTAPS; k++) acc += coef_value(mirror_idx(k));
    return acc;
  endfunction

endpackage

// File: rtl/tfir_csa.sv
module tfir_csa #(
  parameter int W = 24
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);

  logic [W-1:0] maj;

  always_comb begin
    s   = a ^ b ^ c;
    maj = (a & b) | (a & c) | (b & c);
    cy  = {maj[W-2:0], 1'b0};
  end

endmodule

// File: rtl/tfir_terms.sv
module tfir_terms
  import tfir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 24
) (
  input  logic [DATA_W-1:0]             smp,
  output logic [NUNIQ-1:0][ACC_W-1:0]   term_a,
  output logic [NUNIQ-1:0][ACC_W-1:0]   term_b
);

  localparam int EXT_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] smp_ext;

  assign smp_ext = {{EXT_W{smp[DATA_W-1]}}, smp};

  for (genvar j = 0; j < NUNIQ; j++) begin : g_coef
    localparam int SH = coef_shift(j);
    assign term_a[j] = smp_ext << SH;
    if (coef_unit(j)) begin : g_unit
      assign term_b[j] = smp_ext;
    end else begin : g_pow2
      assign term_b[j] = '0;
    end
  end

endmodule

// File: rtl/tfir_stage.sv
module tfir_stage #(
  parameter int W = 24
) (
  input  logic [W-1:0] term_a,
  input  logic [W-1:0] term_b,
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out
);

  logic [W-1:0] s1, c1;

  tfir_csa #(.W(W)) u_csa_lo (
    .a (term_a),
    .b (term_b),
    .c (s_in),
    .s (s1),
    .cy(c1)
  );

  tfir_csa #(.W(W)) u_csa_hi (
    .a (s1),
    .b (c1),
    .c (c_in),
    .s (s_out),
    .cy(c_out)
  );

endmodule

// File: rtl/tfir_shiftadd.sv
module tfir_shiftadd
  import tfir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [DATA_W-1:0]           in_data,
  output logic                        out_valid,
  output logic [DATA_W+GAIN_W-1:0]    out_data
);

  localparam int ACC_W = DATA_W + GAIN_W;
  localparam int NSTG  = NTAPS - 1;

  logic [NUNIQ-1:0][ACC_W-1:0] term_a, term_b;
  logic [NTAPS-1:0][ACC_W-1:0] st_s, st_c;
  logic [NSTG-1:0][ACC_W-1:0]  sum_q, cry_q, sum_d, cry_d;
  logic [ACC_W-1:0]            out_d;
  logic                        ovld_d;

  tfir_terms #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_terms (
    .smp   (in_data),
    .term_a(term_a),
    .term_b(term_b)
  );

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam int J = mirror_idx(k);
    if (k == NTAPS - 1) begin : g_tail
      tfir_stage #(.W(ACC_W)) u_stage (
        .term_a(term_a[J]),
        .term_b(term_b[J]),
        .s_in  ({ACC_W{1'b0}}),
        .c_in  ({ACC_W{1'b0}}),
        .s_out (st_s[k]),
        .c_out (st_c[k])
      );
    end else begin : g_body
      tfir_stage #(.W(ACC_W)) u_stage (
        .term_a(term_a[J]),
        .term_b(term_b[J]),
        .s_in  (sum_q[k]),
        .c_in  (cry_q[k]),
        .s_out (st_s[k]),
        .c_out (st_c[k])
      );
    end
  end

  // Next state: the chain shifts one stage toward the output on each accepted sample
  always_comb begin
    sum_d  = sum_q;
    cry_d  = cry_q;
    out_d  = out_data;
    ovld_d = in_valid;
    if (in_valid) begin
      for (int k = 0; k < NSTG; k++) begin
        sum_d[k] = st_s[k+1];
        cry_d[k] = st_c[k+1];
      end
      out_d = st_s[0] + st_c[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q     <= '0;
      cry_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      sum_q     <= sum_d;
      cry_q     <= cry_d;
      out_data  <= out_d;
      out_valid <= ovld_d;
    end
  end

endmodule

// File: rtl/tfir_chk.sv
module tfir_chk
  import tfir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [DATA_W-1:0]        in_data,
  input logic                     out_valid,
  input logic [DATA_W+GAIN_W-1:0] out_data
);

  localparam int ACC_W = DATA_W + GAIN_W;
  localparam longint HI = longint'(gain_sum()) * ((longint'(1) << (DATA_W - 1)) - 1);
  localparam longint LO = -longint'(gain_sum()) * (longint'(1) << (DATA_W - 1));
  localparam int C0 = coef_value(0);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (in_valid) seen_q <= 1'b1;
  end

  // R2: strobe relation
  p_out_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R4: idle cycles hold the result
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R3: result within full-scale gain bound
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'($signed(out_data)) <= HI && longint'($signed(out_data)) >= LO));

  // R5: first result after reset is the leading coefficient times the sample
  p_first_after_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !seen_q) |=>
      ($signed(out_data) == $signed(ACC_W'(C0 * $signed($past(in_data))))));

endmodule

bind tfir_shiftadd tfir_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/test_tfir_shiftadd.sv
module test_tfir_shiftadd;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [15:0]       in_data;
  logic              out_valid;
  logic [23:0]       out_data;

  int vectors;
  int miscompares;
  bit done;
  int hist [9];
  int lcg;
  int h [9] = '{9, 16, 17, 32, 33, 32, 17, 16, 9};

  tfir_shiftadd i_tfir_shiftadd (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 9; k++) hist[k] = 0;
  endtask

  function automatic int model_push(input int x);
    int acc;
    for (int k = 8; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    acc = 0;
    for (int k = 0; k < 9; k++) acc += h[k] * hist[k];
    return acc;
  endfunction

  // Drive one sample at a falling edge; check the result one cycle later
  task automatic send(input int x, input string req);
    int exp;
    in_valid = 1'b1;
    in_data  = 16'(x);
    exp = model_push(x);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, int'(out_valid), 1);
    check(req, int'($signed(out_data)), exp);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    @(negedge clk);
    check("R5 reset out_valid", int'(out_valid), 0);
    check("R5 reset out_data", int'($signed(out_data)), 0);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    check("R2 no strobe no valid", int'(out_valid), 0);
  endtask

  task automatic t_impulse();
    send(1, "R1 impulse");
    for (int k = 1; k < 9; k++) send(0, "R1 impulse tail");
    send(0, "R1 impulse flushed");
    send(-3, "R1 scaled negative impulse");
    for (int k = 1; k < 10; k++) send(0, "R1 scaled impulse tail");
  endtask

  task automatic t_fullscale();
    for (int k = 0; k < 12; k++) send(32767, "R3 full-scale positive");
    check("R3 positive peak", int'($signed(out_data)), 5930827);
    for (int k = 0; k < 12; k++) send(-32768, "R3 full-scale negative");
    check("R3 negative peak", int'($signed(out_data)), -5931008);
    for (int k = 0; k < 12; k++) send((k % 2 == 0) ? 32767 : -32768, "R3 alternating full-scale");
  endtask

  task automatic t_random();
    for (int k = 0; k < 200; k++) begin
      lcg = lcg * 1103515245 + 12345;
      send(int'($signed(lcg[30:15])), "R6 random signed");
    end
  endtask

  task automatic t_gaps();
    logic [23:0] held;
    for (int k = 0; k < 20; k++) begin
      lcg = lcg * 1103515245 + 12345;
      send(int'($signed(lcg[27:12])), "R4 gapped stream");
      held = out_data;
      for (int g = 0; g < (k % 4); g++) begin
        in_data = 16'(lcg[15:0]);
        @(negedge clk);
        check("R4 idle no valid", int'(out_valid), 0);
        check("R4 idle holds output", int'($signed(out_data)), int'($signed(held)));
      end
    end
  endtask

  task automatic t_midreset();
    for (int k = 0; k < 5; k++) send(1000 + k, "R5 pre-reset stream");
    rst_n = 1'b0;
    @(negedge clk);
    check("R5 mid reset out_data", int'($signed(out_data)), 0);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    send(-1234, "R5 first after reset");
    check("R5 first equals 9x", int'($signed(out_data)), -11106);
    for (int k = 0; k < 9; k++) send(7, "R5 no pre-reset history");
  endtask

  initial begin
    vectors = 0;
    miscompares = 0;
    done = 1'b0;
    lcg = 32'h1F2E3D4C;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    @(negedge clk);
    t_reset_state();
    t_impulse();
    t_fullscale();
    t_random();
    t_gaps();
    t_midreset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule